// File: doc/BRIEF.md
# Edge-Triggered Timer Capture Unit

This unit records the 16-bit count of a free-running timer at the moment an input pin shows a qualifying edge. A 4-bit mode word, loaded through a one-cycle write strobe, either switches the unit off, selects one of four capture behaviours, or selects a code that belongs to some other function. In that last case this unit stays idle. The four capture behaviours are: every falling edge, every rising edge, every fourth rising edge, and every sixteenth rising edge.

A qualifying event copies the timer count into the capture register and raises a sticky flag. Both happen on the same clock edge. Software clears the flag with a clear strobe. The interrupt output is the flag gated by an enable input. The pin must already be synchronized to the clock, and the timer is generated outside this unit.

The prescale counter is kept when software moves straight from one capture behaviour to another. Such a direct move also raises the flag even though no edge occurred. Writing the off code first and then the new capture code gives a clean start with no flag.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset the capture register reads 0, the flag and the interrupt output are 0, and the mode is off (code 0000).
- R2: In mode 0100, each falling edge of the pin copies the timer count into the capture register and sets the flag on the same clock edge. Rising edges are ignored in this mode.
- R3: In mode 0101, each rising edge of the pin copies the timer count and sets the flag on the same clock edge. Falling edges are ignored in this mode.
- R4: In mode 0110 a capture occurs on every 4th rising edge. In mode 0111 a capture occurs on every 16th rising edge. Rising edges between captures change neither the flag nor the capture register.
- R5: While the mode is off (0000) or holds any code outside 0100 to 0111, pin edges change neither the capture register nor the flag, and the prescale counter is held at zero.
- R6: Writing a capture code that differs from the current capture code sets the flag without changing the capture register. The prescale counter is not cleared by this write. For example, after 10 rising edges in mode 0111, a direct write to 0110 makes the very next rising edge capture.
- R7: Writing the off code first and then a capture code raises no flag. The next capture in the new mode then needs the full ratio of rising edges.
- R8: The flag stays set until the clear strobe is asserted. If a set and a clear occur in the same cycle, the set wins.
- R9: The interrupt output equals the flag ANDed with the enable input, with no register in between.
- R10: Writing a capture code equal to the current capture code raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 1 | Synchronized capture pin |
| timerVal | input | 16 | Count of the selected timer |
| modeWrEn | input | 1 | Mode write strobe |
| modeWrData | input | 4 | Mode code to write |
| flagClr | input | 1 | Flag clear strobe |
| irqEn | input | 1 | Interrupt enable |
| captureVal | output | 16 | Captured timer value |
| capFlag | output | 1 | Sticky capture flag |
| irqOut | output | 1 | Flag gated by enable |

## Verification
The hardest state to reach from the ports is a prescale counter left part-way through a count when software switches directly to a capture mode with a smaller ratio. That is the only situation in which a capture arrives early.

The stimulus reaches it in steps:
1. Issue ten rising edges in the divide-by-16 mode.
2. Clear the flag.
3. Write the divide-by-4 code directly. The spurious flag must appear and the capture register must not change.
4. Show that one more rising edge now captures.

The same ten-edge preload is then repeated with an off write placed in between. In that case four edges are needed.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int TW = 16;
  localparam int MAX_DIV = 16;
  localparam int PSW = $clog2(MAX_DIV);

  localparam logic [3:0] MODE_OFF   = 4'b0000;
  localparam logic [3:0] MODE_FALL  = 4'b0100;
  localparam logic [3:0] MODE_RISE  = 4'b0101;
  localparam logic [3:0] MODE_DIV4  = 4'b0110;
  localparam logic [3:0] MODE_DIV16 = 4'b0111;

  typedef struct packed {
    logic latch;
    logic setFlag;
  } ctrlStrb_t;

  function automatic logic isCapture(input logic [3:0] m);
    return m[3:2] == 2'b01;
  endfunction
endpackage

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       modeWrEn,
  input  logic [3:0] modeWrData,
  output ctrlStrb_t  strb
);
  localparam logic [PSW-1:0] LIM4  = PSW'(3);
  localparam logic [PSW-1:0] LIM16 = PSW'(MAX_DIV - 1);

  logic [3:0]     modeQ;
  logic           prevPin;
  logic [PSW-1:0] psCnt, psNext;
  logic           rise, fall, evt, wrChg;

  assign rise = pinIn & ~prevPin;
  assign fall = ~pinIn & prevPin;

  always_comb begin
    evt    = 1'b0;
    psNext = psCnt;
    case (modeQ)
      MODE_FALL: evt = fall;
      MODE_RISE: evt = rise;
      MODE_DIV4: if (rise) begin
        if (psCnt >= LIM4) begin evt = 1'b1; psNext = '0; end
        else psNext = psCnt + 1'b1;
      end
      MODE_DIV16: if (rise) begin
        if (psCnt >= LIM16) begin evt = 1'b1; psNext = '0; end
        else psNext = psCnt + 1'b1;
      end
      default: psNext = '0;
    endcase
  end

  assign wrChg = modeWrEn && isCapture(modeQ) && isCapture(modeWrData)
                 && (modeWrData != modeQ);

  assign strb.latch   = evt;
  assign strb.setFlag = evt | wrChg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_OFF;
      prevPin <= 1'b0;
      psCnt   <= '0;
    end else begin
      prevPin <= pinIn;
      psCnt   <= psNext;
      if (modeWrEn) modeQ <= modeWrData;
    end
  end

  // R5
  ps_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isCapture(modeQ) |=> (psCnt == '0));

  // R5
  no_event_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isCapture(modeQ) |-> !strb.latch);

  // R4
  div16_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.latch && modeQ == MODE_DIV16) |-> (psCnt == LIM16));
endmodule

// File: rtl/cap_dp.sv
module cap_dp
  import cap_pkg::*;
#(
  parameter int W = TW
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrb_t    strb,
  input  logic [W-1:0] timerVal,
  input  logic         flagClr,
  input  logic         irqEn,
  output logic [W-1:0] captureVal,
  output logic         capFlag,
  output logic         irqOut
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      captureVal <= '0;
      capFlag    <= 1'b0;
    end else begin
      if (strb.latch) captureVal <= timerVal;
      if (strb.setFlag) capFlag <= 1'b1;
      else if (flagClr) capFlag <= 1'b0;
    end
  end

  assign irqOut = capFlag & irqEn;

  // R2
  latch_val_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latch |=> (captureVal == $past(timerVal)));

  // R6
  spur_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setFlag && !strb.latch) |=> $stable(captureVal));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !flagClr) |=> capFlag);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pinIn,
  input  logic [TW-1:0] timerVal,
  input  logic          modeWrEn,
  input  logic [3:0]    modeWrData,
  input  logic          flagClr,
  input  logic          irqEn,
  output logic [TW-1:0] captureVal,
  output logic          capFlag,
  output logic          irqOut
);
  ctrlStrb_t strb;

  cap_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .strb(strb)
  );

  cap_dp #(.W(TW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .timerVal(timerVal),
    .flagClr(flagClr), .irqEn(irqEn), .captureVal(captureVal),
    .capFlag(capFlag), .irqOut(irqOut)
  );

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (capFlag && irqEn));
endmodule

// File: tb/sim_edge_capture_unit.sv
module sim_edge_capture_unit;
  logic clk = 0, rstN = 0, pinIn = 0, modeWrEn = 0, flagClr = 0, irqEn = 0;
  logic [15:0] timerVal = 0;
  logic [3:0] modeWrData = 0;
  logic [15:0] captureVal;
  logic capFlag, irqOut;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  edge_capture_unit u0 (.*);

  // {wr, mode, pin, clr, timer, expFlag, expCap}
  localparam logic [39:0] VEC [15] = '{
    {1'b1,4'h4,1'b0,1'b0,16'h1111,1'b0,16'h0000},
    {1'b0,4'h0,1'b1,1'b0,16'h2222,1'b0,16'h0000},
    {1'b0,4'h0,1'b0,1'b0,16'h3333,1'b1,16'h3333},
    {1'b0,4'h0,1'b0,1'b1,16'h4444,1'b0,16'h3333},
    {1'b1,4'h0,1'b1,1'b0,16'h5555,1'b0,16'h3333},
    {1'b0,4'h0,1'b0,1'b0,16'h6666,1'b0,16'h3333},
    {1'b1,4'h5,1'b0,1'b0,16'h7777,1'b0,16'h3333},
    {1'b0,4'h0,1'b1,1'b0,16'h8888,1'b1,16'h8888},
    {1'b0,4'h0,1'b1,1'b1,16'h9999,1'b0,16'h8888},
    {1'b0,4'h0,1'b0,1'b0,16'hAAAA,1'b0,16'h8888},
    {1'b0,4'h0,1'b1,1'b0,16'hBBBB,1'b1,16'hBBBB},
    {1'b1,4'h8,1'b1,1'b1,16'hBBBC,1'b0,16'hBBBB},
    {1'b0,4'h0,1'b0,1'b0,16'hCCCC,1'b0,16'hBBBB},
    {1'b0,4'h0,1'b1,1'b0,16'hDDDD,1'b0,16'hBBBB},
    {1'b1,4'h0,1'b1,1'b0,16'hEEEE,1'b0,16'hBBBB}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [3:0] m, input logic p,
                      input logic c, input logic [15:0] t);
    @(negedge clk);
    modeWrEn = wr; modeWrData = m; pinIn = p; flagClr = c; timerVal = t;
    @(posedge clk); #1;
  endtask

  task automatic idle(input logic p);
    step(0, 0, p, 0, timerVal);
  endtask

  task automatic clr();
    step(0, 0, pinIn, 1, timerVal);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lastCap;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 cap", captureVal, 16'h0);
    chk("R1 flag", {15'b0, capFlag}, 16'h0);
    chk("R1 irq", {15'b0, irqOut}, 16'h0);
    @(negedge clk); rstN = 1;
    idle(0); idle(0);

    // R2 R3 R5 vector walk
    for (int i = 0; i < 15; i++) begin
      step(VEC[i][39], VEC[i][38:35], VEC[i][34], VEC[i][33], VEC[i][32:17]);
      chk($sformatf("R2/R3/R5 vec%0d flag", i), {15'b0, capFlag}, {15'b0, VEC[i][16]});
      chk($sformatf("R2/R3/R5 vec%0d cap", i), captureVal, VEC[i][15:0]);
    end
    idle(0);

    // R4 divide by 4
    step(1, 4'h6, 0, 0, 0);
    chk("R7 off->div4 no flag", {15'b0, capFlag}, 16'h0);
    for (int i = 1; i <= 8; i++) begin
      step(0, 0, 1, 0, 16'h0100 + 16'(i));
      chk($sformatf("R4 div4 edge%0d flag", i), {15'b0, capFlag}, {15'b0, (i % 4) == 0});
      if (i % 4 == 0) chk("R4 div4 cap", captureVal, 16'h0100 + 16'(i));
      step(0, 0, 0, 1, 0);
    end

    // R10 same code rewrite
    step(1, 4'h6, 0, 0, 0);
    idle(0);
    chk("R10 same code no flag", {15'b0, capFlag}, 16'h0);

    // R4 divide by 16 via off
    step(1, 4'h0, 0, 0, 0);
    step(1, 4'h7, 0, 0, 0);
    chk("R7 off->div16 no flag", {15'b0, capFlag}, 16'h0);
    for (int i = 1; i <= 16; i++) begin
      step(0, 0, 1, 0, 16'h0200 + 16'(i));
      chk($sformatf("R4 div16 edge%0d flag", i), {15'b0, capFlag}, {15'b0, i == 16});
      step(0, 0, 0, 1, 0);
    end
    chk("R4 div16 cap", captureVal, 16'h0210);

    // R6 direct switch keeps prescaler
    for (int i = 0; i < 10; i++) begin step(0, 0, 1, 0, 16'h0300); step(0, 0, 0, 0, 0); end
    chk("R6 pre flag", {15'b0, capFlag}, 16'h0);
    step(1, 4'h6, 0, 0, 16'h0301);
    chk("R6 spurious flag", {15'b0, capFlag}, 16'h1);
    chk("R6 cap unchanged", captureVal, 16'h0210);
    clr();
    step(0, 0, 1, 0, 16'h0333);
    chk("R6 early capture flag", {15'b0, capFlag}, 16'h1);
    chk("R6 early capture cap", captureVal, 16'h0333);
    step(0, 0, 0, 1, 0);

    // R7 off route clears prescaler
    step(1, 4'h0, 0, 0, 0);
    step(1, 4'h7, 0, 0, 0);
    for (int i = 0; i < 10; i++) begin step(0, 0, 1, 0, 16'h0400); step(0, 0, 0, 0, 0); end
    step(1, 4'h0, 0, 0, 0);
    step(1, 4'h6, 0, 0, 0);
    chk("R7 no flag", {15'b0, capFlag}, 16'h0);
    for (int i = 1; i <= 4; i++) begin
      step(0, 0, 1, 0, 16'h0440 + 16'(i));
      chk($sformatf("R7 edge%0d flag", i), {15'b0, capFlag}, {15'b0, i == 4});
      step(0, 0, 0, 0, 0);
    end
    chk("R7 cap", captureVal, 16'h0444);

    // R9 interrupt gating
    @(negedge clk); irqEn = 0; #1;
    chk("R9 irq off", {15'b0, irqOut}, 16'h0);
    irqEn = 1; #1;
    chk("R9 irq on", {15'b0, irqOut}, 16'h1);
    clr();
    chk("R9 irq after clear", {15'b0, irqOut}, 16'h0);

    // R8 set wins over clear
    step(1, 4'h5, 0, 0, 0);
    step(1, 4'h0, 0, 0, 0);
    step(1, 4'h5, 0, 0, 0);
    lastCap = 16'h0555;
    step(0, 0, 1, 1, lastCap);
    chk("R8 set beats clear", {15'b0, capFlag}, 16'h1);
    idle(1); idle(1);
    chk("R8 flag sticky", {15'b0, capFlag}, 16'h1);
    clr();
    chk("R8 flag cleared", {15'b0, capFlag}, 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule